// File: doc/BRIEF.md
# Multi-mode memory address generator

This unit forms the effective address of a load or store for a 16-bit word-addressed machine and runs the memory transactions that the access needs. One adder covers two addressing modes. In the first, a signed offset from the low instruction bits is added to the program counter, which already points past the current instruction. In the second, a shorter signed offset is added to a full base register. Indirect modes run two transactions. The first reads a pointer from the counter-relative location, and that pointer becomes the final load or store address. The unit also returns a computed address without touching memory, and it reads through a zero-extended service-vector address.

Register values come in as plain inputs, because the register file and ALU lie outside the unit. The unit outputs the index of the base register so that the register file can supply it. A small combinational selector picks the next program counter. Each operation starts with a one-cycle `start` while the unit is idle. It ends with a single `done` pulse, which carries the loaded value or the computed address.

Top module: `mem_addr_gen`

## Requirements
- R1: Operation code 6 (address only) makes no memory request. `done` rises in the cycle after `start` is accepted, and `result` = `pc_inc` + sign-extended `insn_lo[8:0]`, taken modulo 2^16.
- R2: Code 0 (relative load) reads address `pc_inc` + sext(`insn_lo[8:0]`) and returns the read word in `result`.
- R3: Codes 2 (base load) and 3 (base store) use address `base_val` + sext(`insn_lo[5:0]`). At all times `base_idx` equals `insn_lo[8:6]`.
- R4: Codes 4 (indirect load) and 5 (indirect store) first read `pc_inc` + sext(`insn_lo[8:0]`). The second transaction goes to the word that this first read returned.
- R5: Stores, codes 1, 3 and 5, raise `mem_wr` for the final transaction, with `mem_wdata` equal to `src_val` as sampled at `start`. A store reports `result` = 0.
- R6: Code 7 (vector) reads the address {8'h00, `insn_lo[7:0]`} and returns the read word.
- R7: Once a request is raised, it holds its address, direction and write data until a cycle in which `mem_ready` is high. `mem_rd` and `mem_wr` are never high together.
- R8: Each accepted operation yields exactly one `done` pulse. The pulse comes in the cycle after its last transaction was accepted. `start` is ignored while `busy` is high.
- R9: `next_pc` follows `pc_src`: 1 selects `pc_inc` + sext(`insn_lo[8:0]`), 2 selects `bus_val`, and 0 or 3 selects `pc_inc`.
- R10: After reset `busy`, `done`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation code |
| insn_lo | input | 9 | Low instruction bits: offsets, base index, vector |
| pc_inc | input | 16 | Program counter, already incremented |
| base_val | input | 16 | Base register value |
| src_val | input | 16 | Store data from source register |
| base_idx | output | 3 | Base register index for the register file |
| pc_src | input | 2 | Next-PC select |
| bus_val | input | 16 | Bus value for next-PC select |
| next_pc | output | 16 | Selected next program counter |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Transaction accepted this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Loaded word, address, or zero for stores |

## Verification
The bench builds the unit with its default parameters: a 16-bit address and data path, a 9-bit relative offset, a 6-bit base offset and an 8-bit vector. At these widths the extreme offsets are in reach: +255 and -256 on the relative path, +31 and -32 on the base path. So is address wraparound at the top of the 16-bit space. The bench memory answers after zero, one or three wait cycles. This varies the handshake hold and the spacing of the two indirect transactions, and it leaves room for an ignored `start` pulse during a busy operation.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [2:0] {
      OP_LD_REL  = 3'd0,
      OP_ST_REL  = 3'd1,
      OP_LD_BASE = 3'd2,
      OP_ST_BASE = 3'd3,
      OP_LD_IND  = 3'd4,
      OP_ST_IND  = 3'd5,
      OP_ADDR    = 3'd6,
      OP_VEC     = 3'd7
   } agu_op_e;

   typedef enum logic [1:0] {
      S_IDLE   = 2'd0,
      S_FIRST  = 2'd1,
      S_SECOND = 2'd2
   } seq_state_e;

   localparam logic [1:0] NPC_INC = 2'd0;
   localparam logic [1:0] NPC_ADD = 2'd1;
   localparam logic [1:0] NPC_BUS = 2'd2;

   function automatic logic op_is_store(input agu_op_e o);
      return (o == OP_ST_REL) || (o == OP_ST_BASE) || (o == OP_ST_IND);
   endfunction

   function automatic logic op_is_indirect(input agu_op_e o);
      return (o == OP_LD_IND) || (o == OP_ST_IND);
   endfunction

   function automatic logic op_is_base(input agu_op_e o);
      return (o == OP_LD_BASE) || (o == OP_ST_BASE);
   endfunction

endpackage

// File: rtl/agu_sext.sv
module agu_sext #(
   parameter int IN_W  = 9,
   parameter int OUT_W = 16
) (
   input  logic [IN_W-1:0]  fld,
   output logic [OUT_W-1:0] ext
);
   generate
      if (IN_W >= OUT_W) begin : g_trunc
         assign ext = fld[OUT_W-1:0];
      end else begin : g_extend
         localparam int PAD_W = OUT_W - IN_W;
         assign ext = {{PAD_W{fld[IN_W-1]}}, fld};
      end
   endgenerate
endmodule

// File: rtl/agu_ea_adder.sv
module agu_ea_adder #(
   parameter int ADDR_W = 16,
   parameter int REL_W  = 9,
   parameter int BOFF_W = 6
) (
   input  logic              use_base,
   input  logic [ADDR_W-1:0] pc_inc,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [REL_W-1:0]  rel_fld,
   input  logic [BOFF_W-1:0] boff_fld,
   output logic [ADDR_W-1:0] sum
);
   logic [ADDR_W-1:0] rel_ext;
   logic [ADDR_W-1:0] boff_ext;
   logic [ADDR_W-1:0] opnd_a;
   logic [ADDR_W-1:0] opnd_b;

   agu_sext #(.IN_W(REL_W), .OUT_W(ADDR_W)) u_rel_ext (
      .fld (rel_fld),
      .ext (rel_ext)
   );

   agu_sext #(.IN_W(BOFF_W), .OUT_W(ADDR_W)) u_boff_ext (
      .fld (boff_fld),
      .ext (boff_ext)
   );

   // One shared carry chain; only the operand muxes differ per mode.
   always_comb begin
      opnd_a = use_base ? base_val : pc_inc;
      opnd_b = use_base ? boff_ext : rel_ext;
      sum    = opnd_a + opnd_b;
   end
endmodule

// File: rtl/agu_seq.sv
module agu_seq
   import agu_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  agu_op_e           op,
   input  logic [ADDR_W-1:0] ea,
   input  logic [ADDR_W-1:0] vec_addr,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result
);
   seq_state_e state;
   agu_op_e    op_q;

   assign busy = (state != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         op_q      <= OP_LD_REL;
         mem_addr  <= '0;
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         mem_wdata <= '0;
         done      <= 1'b0;
         result    <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            S_IDLE: begin
               if (start) begin
                  op_q      <= op;
                  mem_wdata <= wdata_in;
                  if (op == OP_ADDR) begin
                     done   <= 1'b1;
                     result <= DATA_W'(ea);
                  end else begin
                     state    <= S_FIRST;
                     mem_addr <= (op == OP_VEC) ? vec_addr : ea;
                     mem_rd   <= !op_is_store(op) || op_is_indirect(op);
                     mem_wr   <= op_is_store(op) && !op_is_indirect(op);
                  end
               end
            end
            S_FIRST: begin
               if (mem_ready) begin
                  if (op_is_indirect(op_q)) begin
                     // Pointer word becomes the final address.
                     state    <= S_SECOND;
                     mem_addr <= ADDR_W'(mem_rdata);
                     mem_rd   <= !op_is_store(op_q);
                     mem_wr   <= op_is_store(op_q);
                  end else begin
                     state  <= S_IDLE;
                     mem_rd <= 1'b0;
                     mem_wr <= 1'b0;
                     done   <= 1'b1;
                     result <= op_is_store(op_q) ? '0 : mem_rdata;
                  end
               end
            end
            S_SECOND: begin
               if (mem_ready) begin
                  state  <= S_IDLE;
                  mem_rd <= 1'b0;
                  mem_wr <= 1'b0;
                  done   <= 1'b1;
                  result <= op_is_store(op_q) ? '0 : mem_rdata;
               end
            end
            default: begin
               state  <= S_IDLE;
               mem_rd <= 1'b0;
               mem_wr <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/mem_addr_gen.sv
module mem_addr_gen
   import agu_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 16,
   parameter int FLD_W    = 9,
   parameter int REL_W    = 9,
   parameter int BOFF_W   = 6,
   parameter int VEC_W    = 8,
   parameter int RIDX_W   = 3,
   parameter int RIDX_LSB = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic [FLD_W-1:0]  insn_lo,
   input  logic [ADDR_W-1:0] pc_inc,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [DATA_W-1:0] src_val,
   output logic [RIDX_W-1:0] base_idx,
   input  logic [1:0]        pc_src,
   input  logic [ADDR_W-1:0] bus_val,
   output logic [ADDR_W-1:0] next_pc,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result
);
   generate
      if (DATA_W != ADDR_W) begin : g_bad_width
         $error("pointer words must be address-wide");
      end
      if (REL_W >= ADDR_W || REL_W > FLD_W) begin : g_bad_rel
         $error("relative offset width out of range");
      end
      if (BOFF_W > RIDX_LSB) begin : g_bad_boff
         $error("base offset overlaps base index field");
      end
      if (RIDX_LSB + RIDX_W > FLD_W) begin : g_bad_ridx
         $error("base index field beyond instruction bits");
      end
      if (VEC_W > ADDR_W || VEC_W > FLD_W) begin : g_bad_vec
         $error("vector width out of range");
      end
   endgenerate

   agu_op_e           op_e;
   logic              use_base;
   logic [ADDR_W-1:0] ea_sum;
   logic [ADDR_W-1:0] rel_sum;
   logic [ADDR_W-1:0] vec_addr;

   assign op_e     = agu_op_e'(op);
   assign use_base = op_is_base(op_e);
   assign base_idx = insn_lo[RIDX_LSB +: RIDX_W];

   agu_ea_adder #(.ADDR_W(ADDR_W), .REL_W(REL_W), .BOFF_W(BOFF_W)) u_adder (
      .use_base (use_base),
      .pc_inc   (pc_inc),
      .base_val (base_val),
      .rel_fld  (insn_lo[REL_W-1:0]),
      .boff_fld (insn_lo[BOFF_W-1:0]),
      .sum      (ea_sum)
   );

   // The next-PC path always wants the counter-relative sum.
   agu_ea_adder #(.ADDR_W(ADDR_W), .REL_W(REL_W), .BOFF_W(BOFF_W)) u_npc_adder (
      .use_base (1'b0),
      .pc_inc   (pc_inc),
      .base_val (base_val),
      .rel_fld  (insn_lo[REL_W-1:0]),
      .boff_fld (insn_lo[BOFF_W-1:0]),
      .sum      (rel_sum)
   );

   generate
      if (VEC_W == ADDR_W) begin : g_vec_full
         assign vec_addr = insn_lo[VEC_W-1:0];
      end else begin : g_vec_zext
         assign vec_addr = {{(ADDR_W-VEC_W){1'b0}}, insn_lo[VEC_W-1:0]};
      end
   endgenerate

   always_comb begin
      case (pc_src)
         NPC_ADD: next_pc = rel_sum;
         NPC_BUS: next_pc = bus_val;
         default: next_pc = pc_inc;
      endcase
   end

   agu_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .op        (op_e),
      .ea        (ea_sum),
      .vec_addr  (vec_addr),
      .wdata_in  (src_val),
      .mem_rdata (mem_rdata),
      .mem_ready (mem_ready),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .busy      (busy),
      .done      (done),
      .result    (result)
   );
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [2:0]        op,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ready,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] result
);
   p_no_rd_wr_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   p_hold_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && !mem_ready) |=>
         ((mem_rd || mem_wr) && $stable(mem_addr) && $stable(mem_wr) && $stable(mem_wdata)));

   p_done_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_busy_needs_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   p_request_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> busy);

   p_addr_only_no_mem_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(start) && !$past(busy) && ($past(op) == 3'd6)) |-> (done && !mem_rd && !mem_wr));

   p_store_result_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(mem_wr)) |-> (result == '0));
endmodule

bind mem_addr_gen agu_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .op        (op),
   .mem_addr  (mem_addr),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .mem_wdata (mem_wdata),
   .mem_ready (mem_ready),
   .busy      (busy),
   .done      (done),
   .result    (result)
);

// File: tb/mem_addr_gen_bench.sv
`timescale 1ns/1ps
module mem_addr_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [8:0]  insn_lo = '0;
   logic [15:0] pc_inc = '0;
   logic [15:0] base_val = '0;
   logic [15:0] src_val = '0;
   logic [2:0]  base_idx;
   logic [1:0]  pc_src = 2'd0;
   logic [15:0] bus_val = '0;
   logic [15:0] next_pc;
   logic [15:0] mem_addr;
   logic        mem_rd;
   logic        mem_wr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        mem_ready = 1'b0;
   logic        busy;
   logic        done;
   logic [15:0] result;

   int n_checks = 0;
   int n_fail   = 0;
   int lat_cfg  = 0;
   int wcnt     = 0;
   int cycles   = 0;
   logic st_q  = 1'b0;
   logic rdy_q = 1'b0;

   // expected transaction: {write, addr, data}
   logic [32:0] exp_txn[$];
   string       exp_tag[$];
   logic [15:0] exp_res[$];
   string       res_tag[$];

   always #5 clk = ~clk;

   mem_addr_gen u_mem_addr_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .insn_lo(insn_lo),
      .pc_inc(pc_inc), .base_val(base_val), .src_val(src_val), .base_idx(base_idx),
      .pc_src(pc_src), .bus_val(bus_val), .next_pc(next_pc), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ready(mem_ready), .busy(busy), .done(done), .result(result)
   );

   function automatic logic [15:0] mv(input logic [15:0] a);
      return {a[7:0], a[15:8]} ^ 16'h1357;
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      st_q  <= start && !busy;
      rdy_q <= mem_ready;
   end

   // Monitor (scoreboard pop) and memory responder.
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            check("R8 done follows accept or start", {15'd0, rdy_q || st_q}, 16'd1);
            if (exp_res.size() == 0) begin
               check("R8 unexpected done", 16'd1, 16'd0);
            end else begin
               check(res_tag.pop_front(), result, exp_res.pop_front());
            end
         end
         if (mem_ready) begin
            mem_ready = 1'b0;
            wcnt = lat_cfg;
         end else if (mem_rd || mem_wr) begin
            if (wcnt == 0) begin
               mem_ready = 1'b1;
               mem_rdata = mv(mem_addr);
               if (exp_txn.size() == 0) begin
                  check("R1 unexpected memory request", mem_addr, 16'hxxxx);
               end else begin
                  logic [32:0] e;
                  string t;
                  e = exp_txn.pop_front();
                  t = exp_tag.pop_front();
                  check({t, " address"}, mem_addr, e[31:16]);
                  check({t, " direction"}, {15'd0, mem_wr}, {15'd0, e[32]});
                  if (e[32]) check({t, " write data"}, mem_wdata, e[15:0]);
               end
            end else begin
               wcnt--;
            end
         end else begin
            wcnt = lat_cfg;
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         summary();
      end
   end

   task automatic do_op(input logic [2:0] o, input logic [8:0] fld, input logic [15:0] pc,
                        input logic [15:0] base, input logic [15:0] src, input int lat,
                        input bit poke);
      logic [15:0] rel, bea, a2, va;
      rel = pc + {{7{fld[8]}}, fld};
      bea = base + {{10{fld[5]}}, fld[5:0]};
      va  = {8'h00, fld[7:0]};
      case (o)
         3'd0: begin exp_txn.push_back({1'b0, rel, 16'h0}); exp_tag.push_back("R2 rel load");
                     exp_res.push_back(mv(rel)); res_tag.push_back("R2 rel load result"); end
         3'd1: begin exp_txn.push_back({1'b1, rel, src}); exp_tag.push_back("R5 rel store");
                     exp_res.push_back(16'h0); res_tag.push_back("R5 store result"); end
         3'd2: begin exp_txn.push_back({1'b0, bea, 16'h0}); exp_tag.push_back("R3 base load");
                     exp_res.push_back(mv(bea)); res_tag.push_back("R3 base load result"); end
         3'd3: begin exp_txn.push_back({1'b1, bea, src}); exp_tag.push_back("R3 base store");
                     exp_res.push_back(16'h0); res_tag.push_back("R5 store result"); end
         3'd4: begin a2 = mv(rel);
                     exp_txn.push_back({1'b0, rel, 16'h0}); exp_tag.push_back("R4 pointer read");
                     exp_txn.push_back({1'b0, a2, 16'h0}); exp_tag.push_back("R4 final read");
                     exp_res.push_back(mv(a2)); res_tag.push_back("R4 indirect load result"); end
         3'd5: begin a2 = mv(rel);
                     exp_txn.push_back({1'b0, rel, 16'h0}); exp_tag.push_back("R4 pointer read");
                     exp_txn.push_back({1'b1, a2, src}); exp_tag.push_back("R4 final write");
                     exp_res.push_back(16'h0); res_tag.push_back("R5 store result"); end
         3'd6: begin exp_res.push_back(rel); res_tag.push_back("R1 address result"); end
         default: begin exp_txn.push_back({1'b0, va, 16'h0}); exp_tag.push_back("R6 vector read");
                     exp_res.push_back(mv(va)); res_tag.push_back("R6 vector result"); end
      endcase
      @(negedge clk);
      while (busy) @(negedge clk);
      lat_cfg = lat;
      @(negedge clk);
      op = o; insn_lo = fld; pc_inc = pc; base_val = base; src_val = src;
      start = 1'b1;
      #1 check("R3 base index", {13'd0, base_idx}, {13'd0, fld[8:6]});
      @(negedge clk);
      start = 1'b0;
      if (poke && busy) begin
         op = 3'd6; insn_lo = 9'h055; src_val = ~src;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 busy after reset", {15'd0, busy}, 16'd0);
      check("R10 done after reset", {15'd0, done}, 16'd0);
      check("R10 request after reset", {14'd0, mem_rd, mem_wr}, 16'd0);

      do_op(3'd6, 9'h0FF, 16'h3000, 16'h0, 16'h0, 0, 0);
      do_op(3'd6, 9'h100, 16'h3000, 16'h0, 16'h0, 0, 0);
      do_op(3'd6, 9'h010, 16'hFFF8, 16'h0, 16'h0, 0, 0);
      do_op(3'd0, 9'h0FF, 16'h30F7, 16'h0, 16'h0, 0, 0);
      do_op(3'd0, 9'h1FD, 16'h0001, 16'h0, 16'h0, 3, 0);
      do_op(3'd1, 9'h1FB, 16'h30F9, 16'h0, 16'hBEEF, 1, 0);
      do_op(3'd2, 9'h01F, 16'h0, 16'h3102, 16'h0, 0, 0);
      do_op(3'd2, 9'h1E0, 16'h0, 16'h0010, 16'h0, 1, 0);
      do_op(3'd3, 9'h0CE, 16'h0, 16'h3102, 16'h0005, 3, 1);
      do_op(3'd4, 9'h005, 16'h4000, 16'h0, 16'h0, 0, 0);
      do_op(3'd4, 9'h1F0, 16'h1234, 16'h0, 16'h0, 3, 1);
      do_op(3'd5, 9'h020, 16'h5000, 16'h0, 16'hA5A5, 1, 0);
      do_op(3'd5, 9'h100, 16'h0080, 16'h0, 16'h0F0F, 0, 1);
      do_op(3'd7, 9'h123, 16'h0, 16'h0, 16'h0, 0, 0);
      do_op(3'd7, 9'h0FF, 16'h0, 16'h0, 16'h0, 3, 1);

      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      check("R8 pending results", 16'(exp_res.size()), 16'd0);
      check("R8 pending transactions", 16'(exp_txn.size()), 16'd0);

      insn_lo = 9'h1F0; pc_inc = 16'h3009; bus_val = 16'h7777;
      pc_src = 2'd0; #1 check("R9 next pc inc", next_pc, 16'h3009);
      pc_src = 2'd1; #1 check("R9 next pc adder", next_pc, 16'h2FF9);
      pc_src = 2'd2; #1 check("R9 next pc bus", next_pc, 16'h7777);
      pc_src = 2'd3; #1 check("R9 next pc spare", next_pc, 16'h3009);
      insn_lo = 9'h0FF; pc_src = 2'd1; #1 check("R9 next pc max offset", next_pc, 16'h3108);
      summary();
   end
endmodule